// File: doc/BRIEF.md
# Conversion Result Holding Register with Coherent Byte Read

This block keeps the most recent 10-bit converter result and shows it to an 8-bit CPU bus as two bytes, a low byte and a high byte. A conversion-complete strobe carries a new value in. The two read-data bytes always come straight from the stored value, so they can be read in any cycle. A configuration input picks where the result sits inside the 16-bit pair: flush right, or flush left. The flush-left placement lets software take an 8-bit result from the high byte alone.

A read strobe on the low byte freezes the stored value until a read strobe on the high byte comes in. A multi-byte read over the narrow bus therefore always returns two halves of the same conversion. A result that arrives while the pair is frozen is thrown away, and a sticky flag records the loss. The next high-byte read clears that flag.

Top module: `conv_result_hold`

## Requirements
- R1: While unlocked, a `conv_done` pulse stores `conv_value`. The read-data outputs show the new value from the cycle after the pulse onward.
- R2: A `rd_lo` pulse without `rd_hi` locks the pair. A `conv_done` in that same cycle, or in any later cycle while the pair stays locked, is discarded and the stored value is kept.
- R3: A `rd_hi` pulse releases the lock. A `conv_done` in the same cycle as `rd_hi` is stored. A `rd_lo` and a `rd_hi` in the same cycle leave the pair unlocked.
- R4: With `left_adj`=0, `rdata_hi` holds value bits 9:8 in its bits 1:0, and `rdata_lo` holds value bits 7:0.
- R5: With `left_adj`=1, `rdata_hi` holds value bits 9:2, and `rdata_lo` holds value bits 1:0 in its bits 7:6.
- R6: A `rd_hi` pulse that comes without any earlier `rd_lo` never locks the pair. The next conversion is stored.
- R7: Bit positions that carry no result bits always read as zero. After reset, both bytes are zero and `dropped` is 0.
- R8: `dropped` goes to 1 in the cycle after a conversion is discarded. It stays at 1 until the cycle after the next `rd_hi` pulse, when it returns to 0.
- R9: A change on `left_adj` alters the read-data outputs in the same cycle, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle pulse: a new result is present on conv_value |
| conv_value | input | 10 | Converter result |
| rd_lo | input | 1 | Read strobe for the low byte |
| rd_hi | input | 1 | Read strobe for the high byte |
| left_adj | input | 1 | 1 = flush-left placement, 0 = flush-right placement |
| rdata_lo | output | 8 | Low byte of the placed result |
| rdata_hi | output | 8 | High byte of the placed result |
| dropped | output | 1 | Sticky flag: a result was discarded while the pair was locked |

## Verification
The assertions assume that `conv_value` is valid whenever `conv_done` is high. They also assume that the read strobes come from one bus master, so a `rd_lo` without a later `rd_hi` is the caller's own choice. The bench drives every input on the falling clock edge, so each strobe lasts exactly one rising edge. It samples on the following falling edge, after the register stage and its combinational placement have settled. The sweep stores every 10-bit value with the pair unlocked and reads it in both placements. Directed sequences then place strobes in the same cycle, or one cycle apart, around the lock.

// File: rtl/crl_pkg.sv
package crl_pkg;
    localparam int unsigned CRL_RES_W  = 10;
    localparam int unsigned CRL_BYTE_W = 8;

    typedef struct packed {
        logic locked;
        logic dropped;
    } crl_lock_t;
endpackage

// File: rtl/crl_lock_ctrl.sv
module crl_lock_ctrl
    import crl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic conv_done,
    input  logic rd_lo,
    input  logic rd_hi,
    output logic wr_en,
    output logic locked,
    output logic dropped
);
    crl_lock_t st_d, st_q;
    logic      gate_open;
    logic      discard;

    always_comb begin
        // A low read without a high read closes the gate in this same cycle.
        gate_open = rd_hi || (!st_q.locked && !rd_lo);
        wr_en     = conv_done && gate_open;
        discard   = conv_done && !gate_open;

        st_d = st_q;
        if (rd_hi) begin
            st_d.locked  = 1'b0;
            st_d.dropped = 1'b0;
        end else begin
            if (rd_lo) begin
                st_d.locked = 1'b1;
            end
            if (discard) begin
                st_d.dropped = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked  = st_q.locked;
    assign dropped = st_q.dropped;
endmodule

// File: rtl/crl_store.sv
module crl_store #(
    parameter int unsigned RES_W = crl_pkg::CRL_RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RES_W-1:0] wr_val,
    output logic [RES_W-1:0] val_q
);
    logic [RES_W-1:0] val_d;

    always_comb begin
        val_d = val_q;
        if (wr_en) begin
            val_d = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end
endmodule

// File: rtl/crl_align.sv
module crl_align #(
    parameter int unsigned RES_W  = crl_pkg::CRL_RES_W,
    parameter int unsigned BYTE_W = crl_pkg::CRL_BYTE_W
) (
    input  logic [RES_W-1:0]  val,
    input  logic              left_adj,
    output logic [BYTE_W-1:0] byte_lo,
    output logic [BYTE_W-1:0] byte_hi
);
    localparam int unsigned PAIR_W = 2 * BYTE_W;
    localparam int unsigned PAD_W  = PAIR_W - RES_W;

    logic [PAIR_W-1:0] pair_r;
    logic [PAIR_W-1:0] pair_l;
    logic [PAIR_W-1:0] pair_sel;

    generate
        if (PAD_W == 0) begin : g_full
            assign pair_r = val;
            assign pair_l = val;
        end else begin : g_pad
            assign pair_r = {{PAD_W{1'b0}}, val};
            assign pair_l = {val, {PAD_W{1'b0}}};
        end
    endgenerate

    always_comb begin
        pair_sel = left_adj ? pair_l : pair_r;
        byte_lo  = pair_sel[BYTE_W-1:0];
        byte_hi  = pair_sel[PAIR_W-1:BYTE_W];
    end
endmodule

// File: rtl/conv_result_hold.sv
module conv_result_hold #(
    parameter int unsigned RES_W  = crl_pkg::CRL_RES_W,
    parameter int unsigned BYTE_W = crl_pkg::CRL_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_value,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic              left_adj,
    output logic [BYTE_W-1:0] rdata_lo,
    output logic [BYTE_W-1:0] rdata_hi,
    output logic              dropped
);
    logic             wr_en;
    logic             locked;
    logic [RES_W-1:0] val_q;

    crl_lock_ctrl u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .wr_en     (wr_en),
        .locked    (locked),
        .dropped   (dropped)
    );

    crl_store #(.RES_W(RES_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_val (conv_value),
        .val_q  (val_q)
    );

    crl_align #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_align (
        .val      (val_q),
        .left_adj (left_adj),
        .byte_lo  (rdata_lo),
        .byte_hi  (rdata_hi)
    );
endmodule

// File: rtl/crl_checker.sv
module crl_checker #(
    parameter int unsigned RES_W  = 10,
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic [RES_W-1:0]  conv_value,
    input logic              rd_lo,
    input logic              rd_hi,
    input logic              left_adj,
    input logic [BYTE_W-1:0] rdata_lo,
    input logic [BYTE_W-1:0] rdata_hi,
    input logic              dropped,
    input logic              locked,
    input logic [RES_W-1:0]  val_q
);
    localparam int unsigned PAD_W = 2 * BYTE_W - RES_W;
    localparam int unsigned HI_SH = RES_W - BYTE_W;

    AST_UNLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !locked && !rd_lo) |=> (val_q == $past(conv_value))); // R1

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !rd_hi) |=> $stable(val_q)); // R2

    AST_HI_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> !locked); // R3

    AST_RELEASE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && rd_hi) |=> (val_q == $past(conv_value))); // R3

    AST_RIGHT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !left_adj |-> ((rdata_hi >> HI_SH) == '0)); // R7

    AST_LEFT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        left_adj |-> ((rdata_lo & BYTE_W'((1 << PAD_W) - 1)) == '0)); // R7

    AST_DROP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && locked && !rd_hi) |=> dropped); // R8

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> !dropped); // R8
endmodule

bind conv_result_hold crl_checker #(.RES_W(RES_W), .BYTE_W(BYTE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .conv_value (conv_value),
    .rd_lo      (rd_lo),
    .rd_hi      (rd_hi),
    .left_adj   (left_adj),
    .rdata_lo   (rdata_lo),
    .rdata_hi   (rdata_hi),
    .dropped    (dropped),
    .locked     (locked),
    .val_q      (val_q)
);

// File: tb/conv_result_hold_tb_top.sv
`timescale 1ns/1ps
module conv_result_hold_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_value = '0;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic       left_adj = 1'b0;
    logic [7:0] rdata_lo;
    logic [7:0] rdata_hi;
    logic       dropped;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    conv_result_hold dut_i (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_value(conv_value),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .left_adj(left_adj),
        .rdata_lo(rdata_lo), .rdata_hi(rdata_hi), .dropped(dropped)
    );

    function automatic logic [7:0] exp_hi(int v, logic adj);
        return adj ? 8'((v / 4) % 256) : 8'(v / 256);
    endfunction

    function automatic logic [7:0] exp_lo(int v, logic adj);
        return adj ? 8'((v % 4) * 64) : 8'(v % 256);
    endfunction

    task automatic chk_val(string req, int v);
        checks++;
        if (rdata_hi !== exp_hi(v, left_adj) || rdata_lo !== exp_lo(v, left_adj)) begin
            errors++;
            $display("FAIL %s: adj=%0b got hi=%h lo=%h expected hi=%h lo=%h",
                     req, left_adj, rdata_hi, rdata_lo, exp_hi(v, left_adj), exp_lo(v, left_adj));
        end
    endtask

    task automatic chk_drop(string req, logic e);
        checks++;
        if (dropped !== e) begin
            errors++;
            $display("FAIL %s: dropped got %0b expected %0b", req, dropped, e);
        end
    endtask

    // Drive one cycle of strobes on a falling edge; result is sampled on the next falling edge.
    task automatic cyc(logic cd, int v, logic lo, logic hi);
        conv_done = cd; conv_value = 10'(v); rd_lo = lo; rd_hi = hi;
        @(negedge clk);
        conv_done = 1'b0; rd_lo = 1'b0; rd_hi = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R7: reset state
        chk_val("R7 reset", 0);
        chk_drop("R7 reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R4 R5 R9: every value, both placements, with placement switched between clock edges
        for (int v = 0; v < 1024; v++) begin
            left_adj = 1'b0;
            cyc(1'b1, v, 1'b0, 1'b0);
            chk_val("R1 R4 right", v);
            left_adj = 1'b1;
            #1;
            chk_val("R5 R9 left", v);
        end
        left_adj = 1'b0;
        #1;
        chk_val("R9 back to right", 1023);

        // R2: a low read locks the pair; a later conversion is discarded
        cyc(1'b1, 10'h155, 1'b0, 1'b0);
        cyc(1'b0, 0, 1'b1, 1'b0);
        cyc(1'b1, 10'h2AA, 1'b0, 1'b0);
        chk_val("R2 locked keeps value", 10'h155);
        chk_drop("R8 set on discard", 1'b1);
        cyc(1'b1, 10'h0F0, 1'b0, 1'b0);
        chk_val("R2 still locked", 10'h155);
        chk_drop("R8 sticky", 1'b1);

        // R3: a conversion in the same cycle as the high read is stored; the flag clears
        cyc(1'b1, 10'h3C3, 1'b0, 1'b1);
        chk_val("R3 write with release", 10'h3C3);
        chk_drop("R8 cleared by high read", 1'b0);
        cyc(1'b1, 10'h011, 1'b0, 1'b0);
        chk_val("R3 unlocked after release", 10'h011);

        // R2: a conversion in the same cycle as the low read is discarded
        cyc(1'b1, 10'h200, 1'b1, 1'b0);
        chk_val("R2 same-cycle low read", 10'h011);
        chk_drop("R8 same-cycle discard", 1'b1);
        cyc(1'b0, 0, 1'b0, 1'b1);
        chk_drop("R8 cleared", 1'b0);

        // R3: low and high read together leave the pair unlocked
        cyc(1'b0, 0, 1'b1, 1'b1);
        cyc(1'b1, 10'h123, 1'b0, 1'b0);
        chk_val("R3 joint read unlocked", 10'h123);
        chk_drop("R3 no discard", 1'b0);

        // R6: high-only reads in left placement never lock
        left_adj = 1'b1;
        cyc(1'b0, 0, 1'b0, 1'b1);
        cyc(1'b1, 10'h2F1, 1'b0, 1'b0);
        chk_val("R6 high-only read no lock", 10'h2F1);
        cyc(1'b0, 0, 1'b0, 1'b1);
        cyc(1'b0, 0, 1'b0, 1'b1);
        cyc(1'b1, 10'h0AB, 1'b0, 1'b0);
        chk_val("R6 repeated high reads", 10'h0AB);
        chk_drop("R6 no discard", 1'b0);

        // R9: placement change while locked alters outputs but not the stored value
        cyc(1'b0, 0, 1'b1, 1'b0);
        cyc(1'b1, 10'h3FF, 1'b0, 1'b0);
        chk_val("R9 left while locked", 10'h0AB);
        left_adj = 1'b0;
        #1;
        chk_val("R9 right while locked", 10'h0AB);
        cyc(1'b0, 0, 1'b0, 1'b1);
        chk_drop("R8 cleared after lock", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule